// File: doc/BRIEF.md
# Programmable Half-Period Gate Generator

A free-running square-wave source whose level is shared by every counter channel of a counting subsystem, either as a counting gate or as an internal index pulse. It advances only on a one-millisecond tick enable supplied from elsewhere. Each level is held for G+1 ticks, so a full cycle lasts 2*(G+1) ms. For example, G = 499 gives a one-second period with a 50% duty cycle.

The divisor G is loaded through a byte-wide configuration path. A 16-bit settings word arrives as two byte writes, low byte first. G sits in bits 15..2 of that word. Bits 1..0 carry a timestamp-resolution code that belongs to other logic, and this block discards it. The setting has no channel number because it is global. A newly written divisor is held as pending until the running half-period ends, so no level is ever cut short or stretched by a write.

Two state machines carry the behaviour:
- The byte collector has the states `WAIT_LO` and `WAIT_HI`.
  - `WAIT_LO` → `WAIT_HI` on a write, which latches the low byte.
  - `WAIT_HI` → `WAIT_LO` on a write, which assembles the word and loads the pending divisor.
- The gate machine has the states `GATE_LOW` and `GATE_HIGH`.
  - `GATE_LOW` → `GATE_HIGH` on a half-period completion.
  - `GATE_HIGH` → `GATE_LOW` on a half-period completion.

Top module: `periodic_gate_gen`

## Requirements
- R1: While reset is asserted, and on leaving it, the gate is low, the tick count is zero, the byte collector expects a low byte, and both the active and the pending divisor equal G_RESET (499).
- R2: Every level of the gate lasts exactly G+1 ticks of the active divisor, so high and low times are equal.
- R3: The gate changes only on a clock edge where the tick enable is high. Cycles without a tick leave the gate and the tick count unchanged.
- R4: A settings word is built from two writes. The first write supplies bits 7..0 and the second supplies bits 15..8. The pending divisor is word bits 15..2 and is updated on the edge of the second write.
- R5: Word bits 1..0 have no effect on the gate output.
- R6: A written divisor below 2 (0 or 1) is stored as 2, which gives a 6-tick period.
- R7: A new divisor takes effect only at the next half-period boundary. The half-period in progress completes with the old value.
- R8: The largest divisor, 16383, yields half-periods of 16384 ticks without wrap or early toggle.
- R9: A lone low-byte write is held indefinitely. It leaves the pending divisor unchanged until a second write arrives, however many cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle enable, once per millisecond |
| cfg_we | input | 1 | Byte write strobe for the settings word |
| cfg_byte | input | 8 | Byte written when cfg_we is high |
| gate_o | output | 1 | Square-wave gate level |

## Verification
The bench targets the following cases:
- **Clamp boundary.** A design without the clamp would run a 2- or 4-tick period after a write of G = 0 or 1.
- **Write inside a half-period.** A design that loads G at once would shorten or stretch the current level.
- **Lone low byte followed by a long idle.** A design with a timeout or a mis-ordered byte pairing would build a wrong G.
- **Sparse ticks.** A design that counts clocks instead of ticks would toggle between ticks.
- **Words that differ only in bits 1..0.** These must give identical waveforms.
- **Top divisor.** This exposes a counter narrower than 14 bits or a compare against G instead of G+1 ticks.

// File: rtl/pgg_pkg.sv
package pgg_pkg;
    typedef enum logic {
        GATE_LOW  = 1'b0,
        GATE_HIGH = 1'b1
    } gate_state_t;

    typedef enum logic {
        WAIT_LO = 1'b0,
        WAIT_HI = 1'b1
    } asm_state_t;
endpackage

// File: rtl/pgg_cfg_collect.sv
module pgg_cfg_collect
    import pgg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int TSW     = 2,
    parameter int G_MIN   = 2,
    parameter int G_RESET = 499,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int GW     = WORD_W - TSW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [GW-1:0]     pend_g_o
);
    asm_state_t        st_q, st_d;
    logic [BYTE_W-1:0] lo_q;
    logic [WORD_W-1:0] word;
    logic [GW-1:0]     g_raw, g_fix;

    assign word  = {byte_i, lo_q};
    assign g_raw = word[WORD_W-1:TSW];
    assign g_fix = (g_raw < GW'(G_MIN)) ? GW'(G_MIN) : g_raw;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WAIT_LO: if (wr_i) st_d = WAIT_HI;
            WAIT_HI: if (wr_i) st_d = WAIT_LO;
            default: st_d = WAIT_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= WAIT_LO;
            lo_q     <= '0;
            pend_g_o <= GW'(G_RESET);
        end else begin
            st_q <= st_d;
            if (wr_i && st_q == WAIT_LO) lo_q <= byte_i;
            if (wr_i && st_q == WAIT_HI) pend_g_o <= g_fix;
        end
    end
endmodule

// File: rtl/pgg_half_timer.sv
module pgg_half_timer #(
    parameter int GW      = 14,
    parameter int G_RESET = 499
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [GW-1:0] pend_g_i,
    output logic [GW-1:0] act_g_o,
    output logic [GW-1:0] cnt_o,
    output logic          done_o
);
    assign done_o = tick_i && (cnt_o == act_g_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            act_g_o <= GW'(G_RESET);
        end else if (tick_i) begin
            if (done_o) begin
                cnt_o   <= '0;
                act_g_o <= pend_g_i;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/periodic_gate_gen.sv
module periodic_gate_gen
    import pgg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int TSW     = 2,
    parameter int G_MIN   = 2,
    parameter int G_RESET = 499
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic              gate_o
);
    localparam int GW = 2 * BYTE_W - TSW;

    logic [GW-1:0] pend_g, act_g, tmr_cnt;
    logic          half_done;
    gate_state_t   state_q, state_d;

    pgg_cfg_collect #(
        .BYTE_W(BYTE_W), .TSW(TSW), .G_MIN(G_MIN), .G_RESET(G_RESET)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_we), .byte_i(cfg_byte),
        .pend_g_o(pend_g)
    );

    pgg_half_timer #(.GW(GW), .G_RESET(G_RESET)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(ms_tick), .pend_g_i(pend_g),
        .act_g_o(act_g), .cnt_o(tmr_cnt), .done_o(half_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_LOW:  if (half_done) state_d = GATE_HIGH;
            GATE_HIGH: if (half_done) state_d = GATE_LOW;
            default:   state_d = GATE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_o = (state_q == GATE_HIGH);
    end
endmodule

// File: rtl/pgg_checker.sv
module pgg_checker #(
    parameter int GW    = 14,
    parameter int G_MIN = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_tick,
    input logic          gate_o,
    input logic [GW-1:0] cnt_i,
    input logic [GW-1:0] act_g_i,
    input logic [GW-1:0] pend_g_i
);
    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |=> !gate_o);

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_tick |=> ($stable(gate_o) && $stable(cnt_i)));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i <= act_g_i);

    // R6
    pend_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_g_i >= GW'(G_MIN));

    // R7
    load_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_g_i != $past(act_g_i)) |-> (gate_o != $past(gate_o)));
endmodule

bind periodic_gate_gen pgg_checker #(.GW(GW), .G_MIN(G_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .gate_o(gate_o),
    .cnt_i(tmr_cnt), .act_g_i(act_g), .pend_g_i(pend_g)
);

// File: tb/tb_periodic_gate_gen.sv
`timescale 1ns/1ps
module tb_periodic_gate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       gate_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // behavioural reference state
    int m_gate, m_cnt, m_act, m_pend, m_lo, m_phase;

    always #2.5 clk = ~clk;

    periodic_gate_gen dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .cfg_we(cfg_we), .cfg_byte(cfg_byte), .gate_o(gate_o)
    );

    task automatic model_reset();
        m_gate = 0; m_cnt = 0; m_act = 499; m_pend = 499; m_lo = 0; m_phase = 0;
    endtask

    task automatic model_edge(input bit tk, input bit we, input int b);
        int g;
        if (tk) begin
            if (m_cnt == m_act) begin
                m_cnt = 0; m_gate = 1 - m_gate; m_act = m_pend;
            end else m_cnt++;
        end
        if (we) begin
            if (m_phase == 0) begin m_lo = b; m_phase = 1; end
            else begin
                g = ((b << 8) | m_lo) >> 2;
                if (g < 2) g = 2;
                m_pend = g; m_phase = 0;
            end
        end
    endtask

    task automatic step(input bit tk, input bit we, input logic [7:0] b, input string tag);
        ms_tick = tk; cfg_we = we; cfg_byte = b;
        @(posedge clk);
        if (rst_n) model_edge(tk, we, int'(b)); else model_reset();
        @(negedge clk);
        vectors++;
        if (int'(gate_o) != m_gate) begin
            fails++;
            $display("FAIL %s: gate_o=%0d expected %0d at t=%0t", tag, gate_o, m_gate, $time);
        end
        ms_tick = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic run(input int n, input int spacing, input string tag);
        for (int i = 0; i < n; i++) step((i % spacing) == 0, 1'b0, 8'h00, tag);
    endtask

    task automatic write_word(input logic [15:0] w, input string tag);
        step(1'b1, 1'b1, w[7:0], tag);
        step(1'b1, 1'b1, w[15:8], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset holds the gate low even with ticks present
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, "R1");
        @(negedge clk); rst_n = 1'b1;
        run(2100, 1, "R2");                       // G=499 default, 1000-tick period
        write_word(16'h0009, "R4");               // G=2, ts=1
        run(60, 3, "R3");                         // sparse ticks
        write_word(16'h0000, "R6");               // G=0 -> 2
        run(40, 1, "R6");
        write_word(16'h0007, "R6");               // G=1, ts=3 -> 2
        run(40, 2, "R6");
        write_word(16'h0014, "R5");               // G=5 ts=0
        run(50, 1, "R5");
        write_word(16'h0016, "R5");               // G=5 ts=2
        run(50, 1, "R5");
        write_word(16'h00A0, "R7");               // G=40
        run(60, 1, "R7");
        write_word(16'h000C, "R7");               // G=3 mid half-period
        run(150, 1, "R7");
        step(1'b1, 1'b1, 8'h30, "R9");            // lone low byte
        run(300, 1, "R9");
        step(1'b1, 1'b1, 8'h00, "R9");            // completes G=12
        run(200, 1, "R9");
        write_word(16'hFFFD, "R8");               // G=16383
        run(33000, 1, "R8");
        run(100, 4, "R3");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule